// File: doc/BRIEF.md
# Port-Power Interrupt Mask and Change-Event Registers

This block is a small register bank for a port-power controller. It watches two status levels, power-good and power-enable, and turns every change of either one, rising or falling, into a sticky event flag. The event flags can be read at two addresses. A read at one address leaves the flags as they are. A read at the other address returns the flags and then clears them. A change that lands in the same cycle as a clearing read is kept, so no change is lost.

An interrupt status register collects the two event flags and five level-type interrupt sources that come from other units. An eight-bit mask register decides which status bits may pull the active-low interrupt pin. A masked source still shows in the status register; the mask only stops it from reaching the pin.

Access is through a plain parallel strobe interface with an address, a read strobe, a write strobe, write data and read data. Read data is registered. A strobe is a single-cycle command that is always accepted, so the interface has no back-pressure. Read data appears on the cycle after the read strobe and stays there until the next read.

Top module: `pse_irq_regbank`

## Requirements
- R1: After reset the mask register at address 01h reads A4h.
- R2: A write to address 01h stores all eight data bits in the mask register, and a later read of 01h returns them.
- R3: Each change of `pgood_i`, rising or falling, sets event bit 4. The bit stays set until it is cleared by a read of 03h.
- R4: Each change of `pwr_en_i`, rising or falling, sets event bit 0. The bit stays set until it is cleared by a read of 03h.
- R5: A read at address 02h returns the event register {3'b0, pg_event, 3'b0, pe_event} and leaves it unchanged.
- R6: A read at address 03h returns the same value as a read of 02h, and the register then holds 00h.
- R7: A change of a status input in the same cycle as a read of 03h leaves its event bit set after the clear.
- R8: The interrupt status register at address 00h reads as follows: bit0 = event bit 0, bit1 = event bit 4, bit2..bit5 = `ext_src_i[0..3]`, bit6 = 0, bit7 = `ext_src_i[4]`.
- R9: `irq_n_o` is low exactly when (status AND mask) is nonzero. It is registered, so it follows the status one cycle later, and it is high after reset.
- R10: A source whose mask bit is 0 still sets its bit in the status register at 00h.
- R11: Bits 7:5 and 3:1 of the event register always read 0. Writes to 00h, 02h and 03h change no register.
- R12: Status inputs that are already high when reset is released do not create events.
- R13: Read data is valid on the cycle after a read strobe and holds until the next read. Addresses 04h through FFh read 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 8 | Register address |
| reg_rd | input | 1 | Read strobe, one cycle per access |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| pgood_i | input | 1 | Power-good status level |
| pwr_en_i | input | 1 | Power-enable status level |
| ext_src_i | input | 5 | Level interrupt sources: load disconnect, detection, classification, overcurrent, supply fault |
| irq_n_o | output | 1 | Interrupt output, active low |

## Verification
The hardest case to reach from the ports is a status change that arrives in exactly the cycle of a clearing read. The bench drives the input toggle on the same falling clock edge that raises the read strobe at 03h. It then checks two things: the read returns the flags as they were before the change, and the following read at 02h still shows the new flag. The other hard case is an input that is already high as reset is released. The bench holds both status inputs high through reset and then reads back an empty event register. The mask logic is swept over all 256 mask values against all 32 source patterns, with both event flags clear and then with both set.

// File: rtl/pse_irq_pkg.sv
package pse_irq_pkg;
  localparam int DW = 8;
  localparam int AW = 8;

  localparam logic [7:0] ADDR_IRQ_STAT = 8'h00;
  localparam logic [7:0] ADDR_IRQ_MASK = 8'h01;
  localparam logic [7:0] ADDR_EVT_KEEP = 8'h02;
  localparam logic [7:0] ADDR_EVT_CLR  = 8'h03;

  localparam logic [7:0] MASK_RESET = 8'hA4;

  // event register bit positions
  localparam int EVT_PE_BIT = 0;
  localparam int EVT_PG_BIT = 4;

  // status register bit positions
  localparam int ST_PE_BIT  = 0;
  localparam int ST_PG_BIT  = 1;
  localparam int ST_LD_BIT  = 2;
  localparam int ST_DET_BIT = 3;
  localparam int ST_CLS_BIT = 4;
  localparam int ST_OC_BIT  = 5;
  localparam int ST_SUP_BIT = 7;

  localparam int N_LVL = 2;  // index 0: power-enable, 1: power-good
  localparam int N_EXT = 5;
endpackage

// File: rtl/pse_chg_detect.sv
module pse_chg_detect #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] chg_o
);
  logic [N-1:0] lvl_q;
  logic         primed_q;

  // The first cycle after reset only loads the levels; edges count after that.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q    <= '0;
      primed_q <= 1'b0;
    end else begin
      lvl_q    <= lvl_i;
      primed_q <= 1'b1;
    end
  end

  assign chg_o = primed_q ? (lvl_i ^ lvl_q) : '0;
endmodule

// File: rtl/pse_sticky_evt.sv
module pse_sticky_evt #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] evt_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic flag_q;
    // A set in the same cycle as a clear wins, so no event is lost.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= (flag_q & ~clr_i) | set_i[i];
    end
    assign evt_o[i] = flag_q;
  end
endmodule

// File: rtl/pse_mask_reg.sv
module pse_mask_reg #(
  parameter int         W   = 8,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mask_o <= RST;
    else if (wr_i) mask_o <= wdata_i;
  end
endmodule

// File: rtl/pse_irq_drive.sv
module pse_irq_drive #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] stat_i,
  input  logic [W-1:0] mask_i,
  output logic         irq_n_o
);
  logic [W-1:0] armed;
  assign armed = stat_i & mask_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_n_o <= 1'b1;
    else        irq_n_o <= ~(|armed);
  end
endmodule

// File: rtl/pse_irq_regbank.sv
module pse_irq_regbank
  import pse_irq_pkg::*;
#(
  parameter int ADDR_W = AW,
  parameter int DATA_W = DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              pgood_i,
  input  logic              pwr_en_i,
  input  logic [N_EXT-1:0]  ext_src_i,
  output logic              irq_n_o
);
  logic [N_LVL-1:0]  lvl;
  logic [N_LVL-1:0]  chg;
  logic [N_LVL-1:0]  evt_bits;
  logic [DATA_W-1:0] mask_q;
  logic [DATA_W-1:0] evt_view;
  logic [DATA_W-1:0] irq_stat;
  logic [DATA_W-1:0] rd_mux;
  logic              hit_stat, hit_mask, hit_keep, hit_clr;
  logic              evt_clr, mask_wr;

  assign hit_stat = (reg_addr == ADDR_W'(ADDR_IRQ_STAT));
  assign hit_mask = (reg_addr == ADDR_W'(ADDR_IRQ_MASK));
  assign hit_keep = (reg_addr == ADDR_W'(ADDR_EVT_KEEP));
  assign hit_clr  = (reg_addr == ADDR_W'(ADDR_EVT_CLR));

  assign evt_clr = reg_rd & hit_clr;
  assign mask_wr = reg_wr & hit_mask;

  assign lvl = {pgood_i, pwr_en_i};

  pse_chg_detect #(.N(N_LVL)) u_chg (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl_i (lvl),
    .chg_o (chg)
  );

  pse_sticky_evt #(.N(N_LVL)) u_evt (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (chg),
    .clr_i (evt_clr),
    .evt_o (evt_bits)
  );

  pse_mask_reg #(.W(DATA_W), .RST(DATA_W'(MASK_RESET))) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (mask_wr),
    .wdata_i (reg_wdata),
    .mask_o  (mask_q)
  );

  always_comb begin
    evt_view             = '0;
    evt_view[EVT_PE_BIT] = evt_bits[0];
    evt_view[EVT_PG_BIT] = evt_bits[1];
  end

  always_comb begin
    irq_stat             = '0;
    irq_stat[ST_PE_BIT]  = evt_bits[0];
    irq_stat[ST_PG_BIT]  = evt_bits[1];
    irq_stat[ST_LD_BIT]  = ext_src_i[0];
    irq_stat[ST_DET_BIT] = ext_src_i[1];
    irq_stat[ST_CLS_BIT] = ext_src_i[2];
    irq_stat[ST_OC_BIT]  = ext_src_i[3];
    irq_stat[ST_SUP_BIT] = ext_src_i[4];
  end

  pse_irq_drive #(.W(DATA_W)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .stat_i  (irq_stat),
    .mask_i  (mask_q),
    .irq_n_o (irq_n_o)
  );

  always_comb begin
    if (hit_stat)                rd_mux = irq_stat;
    else if (hit_mask)           rd_mux = mask_q;
    else if (hit_keep | hit_clr) rd_mux = evt_view;
    else                         rd_mux = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/pse_irq_regbank_chk.sv
module pse_irq_regbank_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] reg_addr,
  input logic       reg_rd,
  input logic       reg_wr,
  input logic [7:0] reg_rdata,
  input logic [1:0] chg,
  input logic [1:0] evt_bits,
  input logic [7:0] irq_stat,
  input logic [7:0] mask_q,
  input logic       irq_n_o
);
  logic quiet;
  assign quiet = (chg == 2'b00);

  assert_keep_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 8'h02 && quiet) |=> $stable(evt_bits));

  assert_clear_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 8'h03 && quiet) |=> (evt_bits == 2'b00));

  assert_pg_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    chg[1] |=> evt_bits[1]);

  assert_pe_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    chg[0] |=> evt_bits[0]);

  assert_collide_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 8'h03 && chg[1]) |=> evt_bits[1]);

  assert_irq_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_stat & mask_q) != 8'h00) |=> !irq_n_o);

  assert_irq_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_stat & mask_q) == 8'h00) |=> irq_n_o);

  assert_reserved_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && (reg_addr == 8'h02 || reg_addr == 8'h03)) |=> ((reg_rdata & 8'hEE) == 8'h00));

  assert_write_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_rd && reg_addr != 8'h01 && quiet) |=> ($stable(evt_bits) && $stable(mask_q)));

  assert_unmapped_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr > 8'h03) |=> (reg_rdata == 8'h00));

  assert_rdata_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata));
endmodule

bind pse_irq_regbank pse_irq_regbank_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_addr  (reg_addr),
  .reg_rd    (reg_rd),
  .reg_wr    (reg_wr),
  .reg_rdata (reg_rdata),
  .chg       (chg),
  .evt_bits  (evt_bits),
  .irq_stat  (irq_stat),
  .mask_q    (mask_q),
  .irq_n_o   (irq_n_o)
);

// File: tb/pse_irq_regbank_bench.sv
module pse_irq_regbank_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = 8'h00;
  logic       rd = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic       pg = 1'b1;
  logic       pe = 1'b1;
  logic [4:0] ext = 5'h00;
  logic [7:0] rdata;
  logic       irq_n;

  int  total = 0;
  int  bad = 0;
  bit  done = 1'b0;
  bit  e_pg = 1'b0;
  bit  e_pe = 1'b0;

  always #10 clk = ~clk;

  pse_irq_regbank u_pse_irq_regbank (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (addr),
    .reg_rd    (rd),
    .reg_wr    (wr),
    .reg_wdata (wdata),
    .reg_rdata (rdata),
    .pgood_i   (pg),
    .pwr_en_i  (pe),
    .ext_src_i (ext),
    .irq_n_o   (irq_n)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(posedge clk); #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(posedge clk);
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic flip(input bit which_pg);
    @(negedge clk);
    if (which_pg) begin pg = ~pg; e_pg = 1'b1; end
    else          begin pe = ~pe; e_pe = 1'b1; end
    @(posedge clk);
  endtask

  function automatic logic [7:0] evt_exp();
    return {3'b000, e_pg, 3'b000, e_pe};
  endfunction

  function automatic logic [7:0] stat_exp(input logic [4:0] s);
    return {s[4], 1'b0, s[3:0], e_pg, e_pe};
  endfunction

  task automatic clear_evt();
    logic [7:0] d;
    rd_reg(8'h03, d);
    e_pg = 1'b0; e_pe = 1'b0;
  endtask

  task automatic irq_sweep(input string tag);
    for (int m = 0; m < 256; m++) begin
      for (int s = 0; s < 32; s++) begin
        wr_reg(8'h01, 8'(m));
        ext = 5'(s);
        @(posedge clk); #1;
        check({tag, " R9 irq_n"}, {7'b0, irq_n},
              {7'b0, ((stat_exp(5'(s)) & 8'(m)) == 8'h00)});
      end
    end
  endtask

  initial begin
    logic [7:0] d;
    // Both status inputs high through reset: no false events (R12).
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(posedge clk); #1;
    check("R9 irq_n after reset", {7'b0, irq_n}, 8'h01);
    rd_reg(8'h01, d); check("R1 mask reset value", d, 8'hA4);
    rd_reg(8'h02, d); check("R12 no event after reset", d, 8'h00);
    rd_reg(8'h00, d); check("R8 status after reset", d, 8'h00);

    // R2: every mask value written and read back
    for (int m = 0; m < 256; m++) begin
      wr_reg(8'h01, 8'(m));
      rd_reg(8'h01, d);
      check("R2 mask readback", d, 8'(m));
    end

    // R3/R4/R5/R6: both edge polarities on each input
    for (int k = 0; k < 4; k++) begin
      flip(1'b1);
      rd_reg(8'h02, d); check("R3 pg change sets bit4", d, 8'h10);
      rd_reg(8'h02, d); check("R5 keep read unchanged", d, 8'h10);
      rd_reg(8'h03, d); check("R6 clear read returns value", d, 8'h10);
      e_pg = 1'b0;
      rd_reg(8'h02, d); check("R6 cleared after read", d, 8'h00);
      flip(1'b0);
      rd_reg(8'h02, d); check("R4 pe change sets bit0", d, 8'h01);
      rd_reg(8'h03, d); check("R6 clear read returns value", d, 8'h01);
      e_pe = 1'b0;
      rd_reg(8'h02, d); check("R6 cleared after read", d, 8'h00);
    end

    // R11: writes to status/event addresses ignored, reserved bits zero
    wr_reg(8'h01, 8'h5A);
    flip(1'b1); flip(1'b0);
    wr_reg(8'h02, 8'hFF);
    wr_reg(8'h03, 8'h00);
    wr_reg(8'h00, 8'hFF);
    rd_reg(8'h02, d); check("R11 event write ignored", d, 8'h11);
    rd_reg(8'h00, d); check("R11 status write ignored", d, 8'h03);
    rd_reg(8'h01, d); check("R11 mask untouched", d, 8'h5A);
    clear_evt();

    // R13: unmapped addresses read zero; data holds between reads
    wr_reg(8'h01, 8'hFF);
    for (int a = 4; a < 256; a++) begin
      rd_reg(8'(a), d); check("R13 unmapped reads zero", d, 8'h00);
    end
    rd_reg(8'h01, d);
    repeat (3) @(posedge clk); #1;
    check("R13 read data holds", rdata, 8'hFF);

    // R7: change lands in the same cycle as a clearing read
    flip(1'b0);
    @(negedge clk); addr = 8'h03; rd = 1'b1; pg = ~pg;
    @(posedge clk); #1 d = rdata;
    check("R7 collide read returns old value", d, 8'h01);
    @(negedge clk); rd = 1'b0;
    e_pe = 1'b0; e_pg = 1'b1;
    rd_reg(8'h02, d); check("R7 new event kept", d, 8'h10);
    clear_evt();

    // R10: fully masked sources still visible in status
    wr_reg(8'h01, 8'h00);
    flip(1'b1);
    for (int s = 0; s < 32; s++) begin
      @(negedge clk); ext = 5'(s);
      rd_reg(8'h00, d); check("R10 masked status visible", d, stat_exp(5'(s)));
      check("R10 masked irq stays high", {7'b0, irq_n}, 8'h01);
    end
    clear_evt();

    // R8/R9: exhaustive mask x source sweep, events clear then set
    irq_sweep("events clear");
    flip(1'b1); flip(1'b0);
    irq_sweep("events set");
    rd_reg(8'h00, d); check("R8 status with events", d, stat_exp(ext));

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule